// File: doc/BRIEF.md
# Dithered 14-bit PWM DAC generator

This block turns a 14-bit data word into a pulse train whose average level, after an external low-pass filter, follows the data word. Time is counted in resolution ticks, which a clock-enable input marks. A conversion cycle is built from a run of equal base periods. Every base period starts with a coarse high pulse whose width comes from the upper data bits. The lower data bits choose a subset of base periods that are one tick longer. Over a full conversion cycle the active time adds up to exactly the 14-bit value.

A mode input picks a short base period (64 ticks, 256 periods per conversion cycle) or a long one (256 ticks, 64 periods). The periods that get the extra tick are those whose bit-reversed index falls below the fine value, so the extra ticks are spread evenly across the cycle. A write stores the word in a pending register. The word and the mode take effect together at the next conversion-cycle boundary. A polarity input chooses whether the active level is high or low.

Top module: `dither_pwm_dac`

## Requirements
- R1: While `rst` is high at a clock edge, the tick and period counters clear, the active word becomes 0 with the short mode, and `pwm_out` takes the inactive level `!out_sel`.
- R2: In short mode (`cyc_sel` = 0 at the boundary) a base period is 64 ticks, a conversion cycle is 256 periods, and data bits 13..8 give the coarse active width in ticks.
- R3: In long mode (`cyc_sel` = 1 at the boundary) a base period is 256 ticks, a conversion cycle is 64 periods, and data bits 13..6 give the coarse active width in ticks.
- R4: Period index p (0-based) gets one extra active tick, placed directly after its coarse pulse, when p bit-reversed over 8 bits (short mode) or 6 bits (long mode) is less than the fine field: bits 7..0 in short mode, bits 5..0 in long mode.
- R5: The number of active ticks in one conversion cycle equals the 14-bit data word.
- R6: With `out_sel` = 1 the active level is high. With `out_sel` = 0 the output is the complement, so the data word sets the low time. `out_sel` is sampled at every tick.
- R7: A write updates only the pending word. The pending word and the level of `cyc_sel` are loaded at the tick that ends a conversion cycle, and they first govern tick 0 of the next cycle.
- R8: A data word of 0 keeps `pwm_out` at the inactive level for the whole conversion cycle.
- R9: When `tick_en` is low, the counters and `pwm_out` do not change.
- R10: `pwm_out` is registered. The value for a tick appears after the clock edge at which `tick_en` is high for that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle enable that marks a resolution tick |
| wr_en | input | 1 | Write strobe for the pending data word |
| wr_data | input | 14 | Data word to write |
| cyc_sel | input | 1 | Base-period select: 0 = 64 ticks, 1 = 256 ticks |
| out_sel | input | 1 | Polarity: 1 = active high, 0 = active low |
| pwm_out | output | 1 | PWM output |

## Verification
Every tick of several full conversion cycles is compared with a bench model. The cycles cover both modes, both polarities, the all-ones and zero words, and random words. A design that reverses the bits wrongly, or compares against the wrong field, puts the extra ticks in the wrong periods. Such a design fails the per-tick check, even when the per-cycle sum of active ticks still comes out right. A write made in the middle of a cycle must not disturb the running cycle, so a design without a working shadow register changes the duty too early. In one cycle `tick_en` drops at random, which exposes counters or an output that move without a tick. The zero word and the reset level catch an output that glitches to its active level.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    localparam int SHORT_LOG = 6;
    localparam int LONG_LOG  = 8;
    localparam int DATA_W    = SHORT_LOG + LONG_LOG;
    localparam int CNT_W     = LONG_LOG;

    typedef logic [DATA_W-1:0] dac_word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic      long_base;
        dac_word_t word;
    } setting_t;

    typedef struct packed {
        cnt_t coarse;
        cnt_t fine;
    } split_t;

    function automatic cnt_t last_tick(input logic long_base);
        cnt_t short_max;
        short_max = cnt_t'((1 << SHORT_LOG) - 1);
        return long_base ? {CNT_W{1'b1}} : short_max;
    endfunction

    function automatic cnt_t last_period(input logic long_base);
        cnt_t short_max;
        short_max = cnt_t'((1 << SHORT_LOG) - 1);
        return long_base ? short_max : {CNT_W{1'b1}};
    endfunction

    function automatic cnt_t rev_index(input cnt_t v, input logic long_base);
        cnt_t r;
        r = '0;
        if (long_base) begin
            for (int i = 0; i < SHORT_LOG; i++) r[i] = v[SHORT_LOG-1-i];
        end else begin
            for (int i = 0; i < LONG_LOG; i++) r[i] = v[LONG_LOG-1-i];
        end
        return r;
    endfunction

    function automatic split_t split_word(input setting_t s);
        split_t p;
        p = '0;
        if (s.long_base) begin
            p.coarse = s.word[DATA_W-1:SHORT_LOG];
            p.fine[SHORT_LOG-1:0] = s.word[SHORT_LOG-1:0];
        end else begin
            p.coarse[DATA_W-LONG_LOG-1:0] = s.word[DATA_W-1:LONG_LOG];
            p.fine = s.word[LONG_LOG-1:0];
        end
        return p;
    endfunction

endpackage

// File: rtl/dpd_timebase.sv
module dpd_timebase
    import dpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic long_base,
    output cnt_t tick_q,
    output cnt_t per_q,
    output logic cyc_end
);

    logic tick_last;
    logic per_last;

    assign tick_last = (tick_q == last_tick(long_base));
    assign per_last  = (per_q == last_period(long_base));
    assign cyc_end   = tick_last && per_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            per_q  <= '0;
        end else if (tick_en) begin
            if (tick_last) begin
                tick_q <= '0;
                per_q  <= per_last ? '0 : per_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // R2
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q <= last_tick(long_base));

    // R3
    per_bound_chk: assert property (@(posedge clk) disable iff (rst)
        per_q <= last_period(long_base));

    // R9
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(tick_q) && $stable(per_q)));

endmodule

// File: rtl/dpd_hold.sv
module dpd_hold
    import dpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  dac_word_t wr_data,
    input  logic      cyc_sel,
    input  logic      load,
    output setting_t  active
);

    dac_word_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr_en) begin
            pend_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (load) begin
            active.word      <= pend_q;
            active.long_base <= cyc_sel;
        end
    end

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

    // R7
    shadow_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (active.word == $past(pend_q) && active.long_base == $past(cyc_sel)));

endmodule

// File: rtl/dpd_shaper.sv
module dpd_shaper
    import dpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  logic     out_sel,
    input  setting_t active,
    input  cnt_t     tick_q,
    input  cnt_t     per_q,
    output logic     pwm_out
);

    split_t parts;
    logic   bonus;
    logic   on_now;

    always_comb begin
        parts  = split_word(active);
        bonus  = rev_index(per_q, active.long_base) < parts.fine;
        on_now = (tick_q < parts.coarse) || (bonus && tick_q == parts.coarse);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= ~out_sel;
        end else if (tick_en) begin
            pwm_out <= out_sel ? on_now : ~on_now;
        end
    end

    // R8
    zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && active.word == '0) |=> (pwm_out == !$past(out_sel)));

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(pwm_out));

    // R2
    past_coarse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && tick_q > parts.coarse) |=> (pwm_out == !$past(out_sel)));

endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac
    import dpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cyc_sel,
    input  logic              out_sel,
    output logic              pwm_out
);

    setting_t active;
    cnt_t     tick_q;
    cnt_t     per_q;
    logic     cyc_end;
    logic     load;

    assign load = tick_en && cyc_end;

    dpd_timebase u_time (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .long_base (active.long_base),
        .tick_q    (tick_q),
        .per_q     (per_q),
        .cyc_end   (cyc_end)
    );

    dpd_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cyc_sel (cyc_sel),
        .load    (load),
        .active  (active)
    );

    dpd_shaper u_shape (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .out_sel (out_sel),
        .active  (active),
        .tick_q  (tick_q),
        .per_q   (per_q),
        .pwm_out (pwm_out)
    );

    // R1
    reset_level_chk: assert property (@(posedge clk)
        rst |=> (pwm_out == !$past(out_sel) && tick_q == '0 && per_q == '0));

endmodule

// File: tb/sim_dither_pwm_dac.sv
`timescale 1ns/1ps
module sim_dither_pwm_dac;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        wr_en;
    logic [13:0] wr_data;
    logic        cyc_sel;
    logic        out_sel;
    logic        pwm_out;

    always #5 clk = ~clk;

    dither_pwm_dac u0 (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cyc_sel (cyc_sel),
        .out_sel (out_sel),
        .pwm_out (pwm_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    int m_tick, m_per, m_data, m_pend, hi_cnt;
    bit m_long, m_pend_long, prev_out, wrapped;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (tick %0d period %0d)",
                     req, act, expv, m_tick, m_per);
        end
    endtask

    function automatic int rev_bits(input int v, input int n);
        int r = 0;
        for (int i = 0; i < n; i++)
            if ((v >> i) & 1) r |= 1 << (n - 1 - i);
        return r;
    endfunction

    function automatic bit has_extra(input int d, input bit lg, input int p);
        int fine = lg ? (d & 63) : (d & 255);
        return rev_bits(p, lg ? 6 : 8) < fine;
    endfunction

    function automatic bit want_high(input int d, input bit lg, input int t, input int p);
        int coarse = lg ? (d >> 6) : (d >> 8);
        return t < coarse + int'(has_extra(d, lg, p));
    endfunction

    task automatic step(input bit en);
        bit hi, expo;
        string tag;
        @(negedge clk);
        tick_en = en;
        @(posedge clk);
        #1;
        if (en) begin
            hi   = want_high(m_data, m_long, m_tick, m_per);
            expo = out_sel ? hi : !hi;
            if (m_data == 0) tag = "R8";
            else if (m_pend != m_data) tag = "R7";
            else if (!out_sel) tag = "R6";
            else if (has_extra(m_data, m_long, m_per)) tag = "R4";
            else tag = m_long ? "R3" : "R2";
            check(pwm_out === expo, tag, int'(pwm_out), int'(expo));
            hi_cnt += int'(hi);
            if (m_tick == (m_long ? 255 : 63)) begin
                m_tick = 0;
                if (m_per == (m_long ? 63 : 255)) begin
                    check(hi_cnt == m_data, "R5", hi_cnt, m_data);
                    hi_cnt  = 0;
                    m_per   = 0;
                    m_data  = m_pend;
                    m_long  = m_pend_long;
                    wrapped = 1'b1;
                end else begin
                    m_per++;
                end
            end else begin
                m_tick++;
            end
            prev_out = pwm_out;
        end else begin
            // R9 / R10: output holds without a tick
            check(pwm_out === prev_out, "R9", int'(pwm_out), int'(prev_out));
        end
    endtask

    task automatic write_word(input int d, input bit cs);
        @(negedge clk);
        tick_en = 1'b0;
        wr_en   = 1'b1;
        wr_data = 14'(d);
        cyc_sel = cs;
        @(posedge clk);
        #1;
        @(negedge clk);
        wr_en = 1'b0;
        m_pend      = d;
        m_pend_long = cs;
    endtask

    task automatic run_cycle(input int idle_pct, input int write_at, input int d, input bit cs);
        int k = 0;
        wrapped = 1'b0;
        while (!wrapped) begin
            if (k == write_at) write_word(d, cs);
            step((idle_pct == 0) ? 1'b1 : (($urandom % 100) >= idle_pct));
            k++;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        cyc_sel = 1'b0; out_sel = 1'b0;
        m_tick = 0; m_per = 0; m_data = 0; m_pend = 0; hi_cnt = 0;
        m_long = 1'b0; m_pend_long = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: inactive level for active-low polarity
        check(pwm_out === 1'b1, "R1", int'(pwm_out), 1);
        @(negedge clk);
        out_sel = 1'b1;
        @(posedge clk);
        #1;
        // R1: inactive level for active-high polarity
        check(pwm_out === 1'b0, "R1", int'(pwm_out), 0);
        @(negedge clk);
        rst = 1'b0;
        prev_out = 1'b0;

        // zero word runs while 0x0207 (long) waits in the pending register
        run_cycle(0, 100, 'h0207, 1'b1);
        // 0x0207 long; all-ones short waits
        run_cycle(0, 5000, 'h3FFF, 1'b0);
        // all-ones short with active-low polarity
        out_sel = 1'b0;
        run_cycle(0, 777, int'($urandom % 16384), 1'b1);
        // random long word, ticks dropped at random
        out_sel = 1'b1;
        run_cycle(30, 50, int'($urandom % 16384), 1'b0);
        // random short word
        run_cycle(0, 9000, 0, 1'b1);
        // zero word in long mode
        run_cycle(0, 10, int'($urandom % 16384), 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule